// File: doc/BRIEF.md
# Framebuffer Pixel Read-Modify-Write Unit

This block edits single pixels of a monochrome frame memory that holds 96 lines of 96 pixels, one bit per pixel, packed as 12 bytes per line. The frame memory itself sits outside the block behind a single-port, byte-wide port with a one-cycle read latency. A pixel request carries a column, a row and a two-bit operation. The block fetches the byte that holds the pixel, changes exactly that one bit, and stores the byte back.

The same request port also carries a bulk fill command. This command overwrites every data byte of the frame with one constant. That constant is chosen at elaboration time from the display polarity parameter. It is 0x00 when a black pixel is stored as 1 (the default), and 0xFF when black is stored as 0. Right after reset the block fills the whole frame with 0xFF by itself, before it accepts any request.

Requests use a valid/ready handshake. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. Requests that cannot change memory are accepted at once and leave `req_ready` high.

Top module: `fb_pixel_rmw`

## Requirements
- R1: While reset is held and for 1152 cycles after it is released, `req_ready` is low. During that time the block writes 0xFF to every address from 0 to 1151. After that, `req_ready` is high.
- R2: A pixel request at column x and row y reads and writes the byte at address y*12 + floor(x/8).
- R3: Bit position x mod 8, counted from the least-significant bit (bit 0), is the only bit of the addressed byte that may change. All other bits are written back with the values that were read.
- R4: Operation code 1 sets the addressed bit to 1.
- R5: Operation code 0 clears the addressed bit to 0.
- R6: Operation code 2 inverts the addressed bit.
- R7: Operation code 3 is accepted and causes no memory access of any kind. `req_ready` stays high in the cycle that follows.
- R8: A pixel request whose x or y is 96 or more is accepted and causes no memory access. `req_ready` stays high.
- R9: A valid pixel update keeps `req_ready` low for exactly three cycles after acceptance. The read is issued in the first of those cycles and the write in the third.
- R10: A request with `req_fill` high writes the polarity fill value to addresses 0 to 1151 in ascending order, one address per cycle, and keeps `req_ready` low for 1152 cycles. With the default polarity the fill value is 0x00. For a fill, `req_x`, `req_y` and `req_op` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_fill | input | 1 | 1: bulk fill command, 0: pixel command |
| req_x | input | 7 | Pixel column |
| req_y | input | 7 | Pixel row (line) |
| req_op | input | 2 | 0 clear, 1 set, 2 toggle, 3 no-op |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (0 = read) |
| mem_addr | output | 11 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |

## Verification
The timeline is measured from the rising edge that accepts a pixel update. The read reaches the memory one edge later, the write three edges later, and `req_ready` returns high on the third edge. A fill raises `req_ready` 1152 edges after acceptance, and the power-up fill raises it 1152 edges after reset is released. Dropped requests and no-ops must leave `req_ready` high at the very next falling edge. The bench drives inputs and reads outputs only on falling edges. It counts falling edges until ready returns and compares that count with the figures above. A memory model logs the cycle number of each access, so the bench can compare read and write cycles with the acceptance cycle. The full memory image is then compared only after the block is idle.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic [1:0] {
    OP_CLR = 2'd0,
    OP_SET = 2'd1,
    OP_TGL = 2'd2,
    OP_NOP = 2'd3
  } pix_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MOD   = 3'd2,
    ST_WRITE = 3'd3,
    ST_FILL  = 3'd4
  } seq_state_e;

  localparam logic [7:0] INIT_BYTE = 8'hFF;

  // Byte that represents an all-white frame for the chosen polarity.
  function automatic logic [7:0] blank_byte(input bit black_is_one);
    return black_is_one ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/fb_addr_calc.sv
module fb_addr_calc #(
  parameter int LINES  = 96,
  parameter int PIXELS = 96,
  parameter int X_W    = 7,
  parameter int Y_W    = 7,
  parameter int ADDR_W = 11
) (
  input  logic [X_W-1:0]    x,
  input  logic [Y_W-1:0]    y,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        bit_idx,
  output logic              in_range
);
  localparam int BPL = PIXELS / 8;
  localparam logic [X_W:0] X_LIM = (X_W+1)'(PIXELS);
  localparam logic [Y_W:0] Y_LIM = (Y_W+1)'(LINES);
  localparam logic [ADDR_W-1:0] BPL_A = ADDR_W'(BPL);

  logic [ADDR_W-1:0] row_base;
  logic [ADDR_W-1:0] col_byte;

  always_comb begin
    row_base = ADDR_W'(y) * BPL_A;
    col_byte = ADDR_W'(x >> 3);
    addr     = row_base + col_byte;
    bit_idx  = x[2:0];
    in_range = ({1'b0, x} < X_LIM) && ({1'b0, y} < Y_LIM);
  end

endmodule

// File: rtl/fb_bit_update.sv
module fb_bit_update (
  input  logic [7:0]       old_byte,
  input  logic [2:0]       bit_idx,
  input  fb_pkg::pix_op_e  op,
  output logic [7:0]       new_byte
);
  import fb_pkg::*;

  logic [7:0] mask;

  for (genvar b = 0; b < 8; b++) begin : g_mask
    assign mask[b] = (bit_idx == 3'(b));
  end

  always_comb begin
    unique case (op)
      OP_SET:  new_byte = old_byte | mask;
      OP_CLR:  new_byte = old_byte & ~mask;
      OP_TGL:  new_byte = old_byte ^ mask;
      default: new_byte = old_byte;
    endcase
  end

  // R3: no more than one bit ever differs between the fetched and rewritten byte
  always_comb begin
    p_one_bit_r3: assert ($countones(new_byte ^ old_byte) <= 1)
      else $error("more than one bit modified");
  end

endmodule

// File: rtl/fb_seq.sv
module fb_seq #(
  parameter int  LINES        = 96,
  parameter int  PIXELS       = 96,
  parameter int  ADDR_W       = 11,
  parameter bit  BLACK_IS_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_fill,
  input  logic              pix_ok,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [2:0]        pix_bit,
  input  fb_pkg::pix_op_e   pix_op,
  input  logic [7:0]        upd_byte,
  output logic              req_ready,
  output logic [2:0]        lat_bit,
  output fb_pkg::pix_op_e   lat_op,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  import fb_pkg::*;

  localparam int TOTAL = LINES * (PIXELS / 8);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);
  localparam logic [7:0] FILL_VAL = blank_byte(BLACK_IS_ONE);

  seq_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      mem_addr  <= '0;
      mem_en    <= 1'b1;
      mem_we    <= 1'b1;
      mem_wdata <= INIT_BYTE;
      req_ready <= 1'b0;
      lat_bit   <= '0;
      lat_op    <= OP_NOP;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_fill) begin
              st        <= ST_FILL;
              mem_addr  <= '0;
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= FILL_VAL;
              req_ready <= 1'b0;
            end else if (pix_ok) begin
              st        <= ST_READ;
              mem_addr  <= pix_addr;
              mem_en    <= 1'b1;
              mem_we    <= 1'b0;
              req_ready <= 1'b0;
              lat_bit   <= pix_bit;
              lat_op    <= pix_op;
            end
          end
        end
        ST_READ: begin
          mem_en <= 1'b0;
          st     <= ST_MOD;
        end
        ST_MOD: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_wdata <= upd_byte;
          st        <= ST_WRITE;
        end
        ST_WRITE: begin
          mem_en    <= 1'b0;
          mem_we    <= 1'b0;
          req_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_addr == LAST) begin
            mem_en    <= 1'b0;
            mem_we    <= 1'b0;
            req_ready <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            mem_addr <= mem_addr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: an accepted in-range pixel request issues a read on the next cycle
  p_read_follows_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_fill && pix_ok) |=> (mem_en && !mem_we && !req_ready));

  // R9: a write to the same address follows every read two cycles later
  p_write_two_later_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> ##2 (mem_en && mem_we && mem_addr == $past(mem_addr, 2)));

  // R7, R8: dropped or no-op requests leave the memory port quiet and ready high
  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_fill && !pix_ok) |=> (!mem_en && req_ready));

  // R10: fill walks upward one address per cycle
  p_fill_walk_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && mem_addr != LAST) |=>
      (mem_en && mem_we && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/fb_pixel_rmw.sv
module fb_pixel_rmw #(
  parameter int LINES        = 96,
  parameter int PIXELS       = 96,
  parameter bit BLACK_IS_ONE = 1'b1,
  parameter int X_W          = $clog2(PIXELS),
  parameter int Y_W          = $clog2(LINES),
  parameter int ADDR_W       = $clog2(LINES * (PIXELS / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fill,
  input  logic [X_W-1:0]    req_x,
  input  logic [Y_W-1:0]    req_y,
  input  logic [1:0]        req_op,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import fb_pkg::*;

  logic [ADDR_W-1:0] pix_addr;
  logic [2:0]        pix_bit;
  logic              pix_in_range;
  logic              pix_ok;
  pix_op_e           pix_op;
  logic [2:0]        lat_bit;
  pix_op_e           lat_op;
  logic [7:0]        upd_byte;

  assign pix_op = pix_op_e'(req_op);
  assign pix_ok = pix_in_range && (pix_op != OP_NOP);

  fb_addr_calc #(
    .LINES (LINES),
    .PIXELS(PIXELS),
    .X_W   (X_W),
    .Y_W   (Y_W),
    .ADDR_W(ADDR_W)
  ) u_addr (
    .x       (req_x),
    .y       (req_y),
    .addr    (pix_addr),
    .bit_idx (pix_bit),
    .in_range(pix_in_range)
  );

  fb_bit_update u_upd (
    .old_byte(mem_rdata),
    .bit_idx (lat_bit),
    .op      (lat_op),
    .new_byte(upd_byte)
  );

  fb_seq #(
    .LINES       (LINES),
    .PIXELS      (PIXELS),
    .ADDR_W      (ADDR_W),
    .BLACK_IS_ONE(BLACK_IS_ONE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_fill (req_fill),
    .pix_ok   (pix_ok),
    .pix_addr (pix_addr),
    .pix_bit  (pix_bit),
    .pix_op   (pix_op),
    .upd_byte (upd_byte),
    .req_ready(req_ready),
    .lat_bit  (lat_bit),
    .lat_op   (lat_op),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

endmodule

// File: tb/tb_fb_pixel_rmw.sv
module tb_fb_pixel_rmw;
  localparam int NB = 1152;
  localparam logic [7:0] FILL_EXP = 8'h00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_fill = 1'b0;
  logic [6:0] req_x = '0, req_y = '0;
  logic [1:0] req_op = '0;
  logic req_ready, mem_en, mem_we;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  logic [7:0] mem [0:NB-1];
  logic [7:0] expm [0:NB-1];
  int cyc = 0, nrd = 0, nwr = 0, rd_cyc = 0, wr_cyc = 0, acc_cyc = 0;
  int last_wa = 0;
  logic [7:0] last_wd = '0, last_rd = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  fb_pixel_rmw dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fill(req_fill), .req_x(req_x), .req_y(req_y), .req_op(req_op),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Frame memory model and access log
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr++; wr_cyc = cyc; last_wa = int'(mem_addr); last_wd = mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr];
        last_rd = mem[mem_addr];
        nrd++; rd_cyc = cyc;
      end
    end
    if (req_valid && req_ready) acc_cyc = cyc;
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_diff();
    for (int i = 0; i < NB; i++) if (mem[i] !== expm[i]) return i;
    return -1;
  endfunction

  task automatic cmp_mem(input string tag);
    int d = first_diff();
    if (d < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'(mem[d]), int'(expm[d]));
  endtask

  task automatic ready_wait(output int n);
    n = 0;
    while (!req_ready) begin @(negedge clk); n++; end
  endtask

  task automatic pixel(input int x, input int y, input int op);
    int nr0 = nrd, nw0 = nwr, n, idx;
    logic [7:0] m;
    bit ok;
    req_valid = 1'b1; req_fill = 1'b0;
    req_x = 7'(x); req_y = 7'(y); req_op = 2'(op);
    @(negedge clk);
    req_valid = 1'b0;
    ready_wait(n);
    ok = (x < 96) && (y < 96) && (op != 3);
    if (ok) begin
      idx = y * 12 + x / 8;
      m = 8'(1 << (x % 8));
      case (op)
        1: expm[idx] = expm[idx] | m;
        0: expm[idx] = expm[idx] & ~m;
        default: expm[idx] = expm[idx] ^ m;
      endcase
      chk(n == 3, "R9 busy cycles", n, 3);
      chk((rd_cyc - acc_cyc == 1) && (wr_cyc - acc_cyc == 3), "R9 read/write cycle",
          (rd_cyc - acc_cyc) * 10 + (wr_cyc - acc_cyc), 13);
      chk(last_wa == idx, "R2 address", last_wa, idx);
      chk(((last_wd ^ last_rd) & ~m) == 8'h00, "R3 other bits", int'(last_wd), int'(last_rd));
      case (op)
        1: cmp_mem("R4 set");
        0: cmp_mem("R5 clear");
        default: cmp_mem("R6 toggle");
      endcase
    end else begin
      chk(n == 0 && nrd == nr0 && nwr == nw0, (op == 3 && x < 96 && y < 96) ? "R7 no-op" : "R8 out of range",
          (nrd - nr0) + (nwr - nw0) + n, 0);
    end
  endtask

  task automatic fill(input int x, input int y, input int op);
    int nr0 = nrd, nw0 = nwr, n;
    req_valid = 1'b1; req_fill = 1'b1;
    req_x = 7'(x); req_y = 7'(y); req_op = 2'(op);
    @(negedge clk);
    req_valid = 1'b0; req_fill = 1'b0;
    ready_wait(n);
    for (int i = 0; i < NB; i++) expm[i] = FILL_EXP;
    chk(n == NB, "R10 fill cycles", n, NB);
    chk(nwr - nw0 == NB && nrd == nr0, "R10 fill writes", nwr - nw0, NB);
    chk(last_wa == NB - 1, "R10 last address", last_wa, NB - 1);
    cmp_mem("R10 fill value");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n, r;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'h5A; expm[i] = 8'hFF; end
    r = int'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready low in reset", int'(req_ready), 0);
    rst = 1'b0;
    ready_wait(n);
    chk(n == NB, "R1 init cycles", n, NB);
    cmp_mem("R1 init 0xFF");

    // Directed corners
    pixel(0, 0, 0);
    pixel(0, 0, 1);
    pixel(7, 3, 0);
    pixel(8, 3, 2);
    pixel(8, 3, 2);
    pixel(95, 95, 0);
    pixel(95, 0, 2);
    pixel(96, 0, 1);
    pixel(0, 96, 0);
    pixel(127, 127, 2);
    pixel(10, 10, 3);
    fill(5, 5, 0);
    pixel(95, 95, 1);
    pixel(0, 0, 1);
    pixel(0, 0, 3);

    // Random mix
    for (int k = 0; k < 160; k++) begin
      pixel(int'($urandom_range(103, 0)), int'($urandom_range(103, 0)),
            int'($urandom_range(3, 0)));
    end
    fill(int'($urandom_range(127, 0)), 3, 1);
    for (int k = 0; k < 40; k++) begin
      pixel(int'($urandom_range(95, 0)), int'($urandom_range(95, 0)),
            int'($urandom_range(2, 0)));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule